// File: doc/BRIEF.md
# Floppy Controller Command-Phase Sequencer

This block is the host-facing side of a floppy disk controller's data port. The host writes command bytes and reads result bytes through one byte-wide port. The block moves through four phases. It waits for an opcode, collects that opcode's argument bytes, runs an execution step, and then streams the result bytes back. A main status byte tells the host, on every cycle, whether the port will take a byte, give a byte, or neither.

The first byte of a command is matched against an opcode table. Each entry has a code, a bit mask and an argument count. Entries are tried in a fixed priority order, and a catch-all entry with an all-zero mask takes any byte that matches nothing else. The media, DMA and head-positioning side is replaced by an internal execution stub. The stub answers each command after a fixed latency with a result length (possibly zero), the result bytes, and a request to raise the interrupt. It also keeps the few pieces of state that later commands report: the sought cylinder, the drive, and the non-DMA flag.

Phases and transitions: `PH_CMD_IDLE` goes to `PH_CMD_ARGS` on an opcode that takes arguments, or straight to `PH_EXEC` on a zero-argument opcode. `PH_CMD_ARGS` goes to `PH_EXEC` on its last argument byte. `PH_EXEC` goes to `PH_RESULT` when the stub finishes with a non-zero length, or back to `PH_CMD_IDLE` when the length is zero. `PH_RESULT` goes to `PH_CMD_IDLE` when the final result byte is read.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the status byte is 0x80, the interrupt is low, and a data read returns 0x00.
- R2: The status byte depends only on the phase, with bit 7 = port ready, bit 6 = controller-to-host, bit 5 = non-DMA execution, bit 4 = busy, and bits 3..0 zero. The values are 0x80 while waiting for an opcode, 0x90 while collecting arguments, 0x10 or 0x30 during execution, and 0xD0 during the result phase.
- R3: The opcode byte selects the first entry, in priority order, for which (byte AND mask) equals the entry's code. The entries in order are: read 0x06/0x1F (8 arguments), write 0x05/0x3F (8), seek 0x0F/0xFF (2), sense-interrupt 0x08/0xFF (0), specify 0x03/0xFF (2), configure 0x13/0xFF (3), lock 0x14/0x7F (0), version 0x10/0xFF (0), then the catch-all 0x00/0x00 (0).
- R4: A zero-argument opcode enters execution on the clock edge that accepts it. Execution lasts EXEC_LAT+1 cycles for read and write, and 2 cycles for every other command.
- R5: A data write is ignored while the block is executing or presenting a result.
- R6: A data read returns 0x00 and changes nothing unless the block is in the result phase.
- R7: Reading the final result byte returns the block to status 0x80 and drops the interrupt.
- R8: The catch-all entry gives a one-byte result of 0x80 and does not raise the interrupt.
- R9: Version returns one byte, 0x90. Lock returns one byte: 0x10 if opcode bit 7 is set, otherwise 0x00.
- R10: Read and write return seven bytes: {arg0[2:0]}, {opcode bit 7 as the multi-track flag in bit 0}, 0x00, arg1, arg2, arg3, arg4. They raise the interrupt as the result phase begins.
- R11: Seek stores the drive (arg0[1:0]) and the cylinder (arg1), returns no result and raises the interrupt. Sense-interrupt returns {0x20 | drive, cylinder} while the interrupt is pending, and one byte of 0x80 when it is not.
- R12: Bit 0 of specify's second argument sets the non-DMA flag. The flag shows as status bit 5 only during read or write execution.
- R13: A command with a zero result length (specify, configure, seek) returns directly to status 0x80 without a result phase. Specify and configure leave the interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host writes wr_data to the data port this cycle |
| wr_data | input | 8 | Command or argument byte |
| rd_en | input | 1 | Host reads the data port this cycle |
| rd_data | output | 8 | Result byte during a result-phase read, else 0x00 |
| msr | output | 8 | Main status byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are host accesses that land in the wrong phase while a command is still running. Examples are a write during the read/write execution window, or a write in the middle of a multi-byte result. In either case the sequencer must neither restart nor lose its place in the result. The stimulus issues a full eight-argument read and then, within the EXEC_LAT window, pushes a write and a read at the port. It repeats this with a write between two result reads. A behavioural model predicts the status byte, the interrupt and the read data on every clock, so any disturbance of the phase or the result pointer shows up at once.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    localparam int NUM_OPS = 9;
    localparam int ENT_ARGC_W = 5;

    typedef enum logic [3:0] {
        OP_READ, OP_WRITE, OP_SEEK, OP_SENSE, OP_SPECIFY,
        OP_CONFIG, OP_LOCK, OP_VERSION, OP_UNKNOWN
    } op_e;

    typedef enum logic [1:0] {
        PH_CMD_IDLE, PH_CMD_ARGS, PH_EXEC, PH_RESULT
    } phase_e;

    typedef struct packed {
        logic [7:0]            code;
        logic [7:0]            mask;
        logic [ENT_ARGC_W-1:0] argc;
    } op_entry_t;

    // status bit positions
    localparam int ST_READY = 7;
    localparam int ST_TOHOST = 6;
    localparam int ST_NONDMA = 5;
    localparam int ST_BUSY = 4;

    // Priority-ordered opcode table: a lower index wins.
    function automatic op_entry_t op_entry(input int unsigned idx);
        case (idx)
            0:       return '{code: 8'h06, mask: 8'h1F, argc: 5'd8};
            1:       return '{code: 8'h05, mask: 8'h3F, argc: 5'd8};
            2:       return '{code: 8'h0F, mask: 8'hFF, argc: 5'd2};
            3:       return '{code: 8'h08, mask: 8'hFF, argc: 5'd0};
            4:       return '{code: 8'h03, mask: 8'hFF, argc: 5'd2};
            5:       return '{code: 8'h13, mask: 8'hFF, argc: 5'd3};
            6:       return '{code: 8'h14, mask: 8'h7F, argc: 5'd0};
            7:       return '{code: 8'h10, mask: 8'hFF, argc: 5'd0};
            default: return '{code: 8'h00, mask: 8'h00, argc: 5'd0};
        endcase
    endfunction

endpackage

// File: rtl/fdc_op_decode.sv
module fdc_op_decode
    import fdc_seq_pkg::*;
#(
    parameter int ARGC_W = 5
) (
    input  logic [7:0]        opcode,
    output op_e               op_id,
    output logic [ARGC_W-1:0] argc
);
    localparam int SEL_W = $clog2(NUM_OPS);

    logic [NUM_OPS-1:0] hit;
    logic [SEL_W-1:0]   sel;
    op_entry_t          chosen;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_match
        localparam op_entry_t ENT = op_entry(i);
        assign hit[i] = ((opcode & ENT.mask) == ENT.code);
    end

    // scan from the back so the lowest matching index is kept
    always_comb begin
        sel = SEL_W'(NUM_OPS - 1);
        for (int i = NUM_OPS - 1; i >= 0; i--) begin
            if (hit[i]) sel = SEL_W'(i);
        end
    end

    always_comb begin
        chosen = op_entry(32'(sel));
        op_id  = op_e'(sel);
        argc   = ARGC_W'(chosen.argc);
    end

endmodule

// File: rtl/fdc_exec_stub.sv
module fdc_exec_stub
    import fdc_seq_pkg::*;
#(
    parameter int ARG_DEPTH = 17,
    parameter int RES_DEPTH = 15,
    parameter int EXEC_LAT = 4,
    parameter int LEN_W = $clog2(RES_DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  op_e                           op_id,
    input  logic [7:0]                    opcode,
    input  logic [ARG_DEPTH-1:0][7:0]     args,
    input  logic                          irq_pend,
    output logic                          done,
    output logic [LEN_W-1:0]              res_len,
    output logic [RES_DEPTH-1:0][7:0]     res_bytes,
    output logic                          raise_irq,
    output logic                          nondma
);
    localparam int CNT_W = $clog2(EXEC_LAT + 1);

    logic [CNT_W-1:0]          cnt_q;
    logic [7:0]                cyl_q;
    logic [1:0]                drv_q;
    logic                      nd_q;
    logic [RES_DEPTH-1:0][7:0] nxt_bytes;
    logic [LEN_W-1:0]          nxt_len;
    logic                      nxt_raise;
    logic [CNT_W-1:0]          nxt_lat;

    always_comb begin
        nxt_bytes = '0;
        nxt_len   = '0;
        nxt_raise = 1'b0;
        nxt_lat   = CNT_W'(1);
        unique case (op_id)
            OP_READ, OP_WRITE: begin
                nxt_bytes[0] = {5'b0, args[0][2:0]};
                nxt_bytes[1] = {7'b0, opcode[7]};
                nxt_bytes[2] = 8'h00;
                nxt_bytes[3] = args[1];
                nxt_bytes[4] = args[2];
                nxt_bytes[5] = args[3];
                nxt_bytes[6] = args[4];
                nxt_len      = LEN_W'(7);
                nxt_raise    = 1'b1;
                nxt_lat      = CNT_W'(EXEC_LAT);
            end
            OP_SEEK: nxt_raise = 1'b1;
            OP_SENSE: begin
                if (irq_pend) begin
                    nxt_bytes[0] = {6'b001000, drv_q};
                    nxt_bytes[1] = cyl_q;
                    nxt_len      = LEN_W'(2);
                end else begin
                    nxt_bytes[0] = 8'h80;
                    nxt_len      = LEN_W'(1);
                end
            end
            OP_SPECIFY, OP_CONFIG: nxt_len = '0;
            OP_LOCK: begin
                nxt_bytes[0] = opcode[7] ? 8'h10 : 8'h00;
                nxt_len      = LEN_W'(1);
            end
            OP_VERSION: begin
                nxt_bytes[0] = 8'h90;
                nxt_len      = LEN_W'(1);
            end
            default: begin
                nxt_bytes[0] = 8'h80;
                nxt_len      = LEN_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            cyl_q     <= '0;
            drv_q     <= '0;
            nd_q      <= 1'b0;
            res_bytes <= '0;
            res_len   <= '0;
            raise_irq <= 1'b0;
        end else if (start) begin
            cnt_q     <= nxt_lat;
            res_bytes <= nxt_bytes;
            res_len   <= nxt_len;
            raise_irq <= nxt_raise;
            if (op_id == OP_SEEK) begin
                cyl_q <= args[1];
                drv_q <= args[0][1:0];
            end
            if (op_id == OP_SPECIFY) nd_q <= args[1][0];
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done   = (cnt_q == CNT_W'(1));
    assign nondma = nd_q;

endmodule

// File: rtl/fdc_result_buf.sv
module fdc_result_buf #(
    parameter int RES_DEPTH = 15,
    parameter int LEN_W = $clog2(RES_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [LEN_W-1:0]          load_len,
    input  logic [RES_DEPTH-1:0][7:0] load_bytes,
    input  logic                      pop,
    output logic [7:0]                head,
    output logic                      last
);
    logic [RES_DEPTH-1:0][7:0] mem_q;
    logic [LEN_W-1:0]          len_q;
    logic [LEN_W-1:0]          ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
            len_q <= '0;
            ptr_q <= '0;
        end else if (load) begin
            mem_q <= load_bytes;
            len_q <= load_len;
            ptr_q <= '0;
        end else if (pop) begin
            ptr_q <= ptr_q + LEN_W'(1);
        end
    end

    assign head = (32'(ptr_q) < RES_DEPTH) ? mem_q[ptr_q] : 8'h00;
    assign last = (ptr_q + LEN_W'(1) == len_q);

endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
    import fdc_seq_pkg::*;
#(
    parameter int ARG_DEPTH = 17,
    parameter int RES_DEPTH = 15,
    parameter int EXEC_LAT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic [7:0] msr,
    output logic       irq
);
    localparam int ARGC_W = $clog2(ARG_DEPTH + 1);
    localparam int PTR_W = $clog2(ARG_DEPTH);
    localparam int LEN_W = $clog2(RES_DEPTH + 1);

    phase_e                    state_q, state_d;
    op_e                       dec_id, op_q;
    logic [ARGC_W-1:0]         dec_argc, remain_q;
    logic [7:0]                opcode_q;
    logic [PTR_W-1:0]          ptr_q;
    logic [ARG_DEPTH-1:0][7:0] args_q;
    logic                      start_q, launch, irq_q;
    logic                      ex_done, ex_raise, ex_nondma;
    logic [LEN_W-1:0]          ex_len;
    logic [RES_DEPTH-1:0][7:0] ex_bytes;
    logic                      res_load, res_pop, res_last;
    logic [7:0]                res_head;
    logic                      final_read;

    fdc_op_decode #(.ARGC_W(ARGC_W)) u_dec (
        .opcode(wr_data), .op_id(dec_id), .argc(dec_argc)
    );

    fdc_exec_stub #(
        .ARG_DEPTH(ARG_DEPTH), .RES_DEPTH(RES_DEPTH),
        .EXEC_LAT(EXEC_LAT), .LEN_W(LEN_W)
    ) u_exec (
        .clk(clk), .rst_n(rst_n), .start(start_q), .op_id(op_q),
        .opcode(opcode_q), .args(args_q), .irq_pend(irq_q),
        .done(ex_done), .res_len(ex_len), .res_bytes(ex_bytes),
        .raise_irq(ex_raise), .nondma(ex_nondma)
    );

    fdc_result_buf #(.RES_DEPTH(RES_DEPTH), .LEN_W(LEN_W)) u_res (
        .clk(clk), .rst_n(rst_n), .load(res_load), .load_len(ex_len),
        .load_bytes(ex_bytes), .pop(res_pop), .head(res_head),
        .last(res_last)
    );

    // next-phase logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_CMD_IDLE: if (wr_en)
                state_d = (dec_argc == '0) ? PH_EXEC : PH_CMD_ARGS;
            PH_CMD_ARGS: if (wr_en && remain_q == ARGC_W'(1))
                state_d = PH_EXEC;
            PH_EXEC: if (ex_done)
                state_d = (ex_len == '0) ? PH_CMD_IDLE : PH_RESULT;
            PH_RESULT: if (rd_en && res_last)
                state_d = PH_CMD_IDLE;
        endcase
    end

    assign launch     = (state_q != PH_EXEC) && (state_d == PH_EXEC);
    assign res_load   = (state_q == PH_EXEC) && ex_done && (ex_len != '0);
    assign res_pop    = (state_q == PH_RESULT) && rd_en;
    assign final_read = res_pop && res_last;

    // state register, launch pulse and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_CMD_IDLE;
            start_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= launch;
            if (state_q == PH_EXEC && ex_done && ex_raise) irq_q <= 1'b1;
            else if (final_read) irq_q <= 1'b0;
        end
    end

    // command byte capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_UNKNOWN;
            opcode_q <= '0;
            remain_q <= '0;
            ptr_q    <= '0;
            args_q   <= '0;
        end else if (wr_en && state_q == PH_CMD_IDLE) begin
            op_q     <= dec_id;
            opcode_q <= wr_data;
            remain_q <= dec_argc;
            ptr_q    <= '0;
        end else if (wr_en && state_q == PH_CMD_ARGS) begin
            args_q[ptr_q] <= wr_data;
            ptr_q         <= ptr_q + PTR_W'(1);
            remain_q      <= remain_q - ARGC_W'(1);
        end
    end

    // outputs by phase
    always_comb begin
        msr = 8'h00;
        unique case (state_q)
            PH_CMD_IDLE: msr[ST_READY] = 1'b1;
            PH_CMD_ARGS: begin
                msr[ST_READY] = 1'b1;
                msr[ST_BUSY]  = 1'b1;
            end
            PH_EXEC: begin
                msr[ST_BUSY]   = 1'b1;
                msr[ST_NONDMA] = ex_nondma &&
                                 (op_q == OP_READ || op_q == OP_WRITE);
            end
            PH_RESULT: begin
                msr[ST_READY]  = 1'b1;
                msr[ST_TOHOST] = 1'b1;
                msr[ST_BUSY]   = 1'b1;
            end
        endcase
        rd_data = res_pop ? res_head : 8'h00;
    end

    assign irq = irq_q;

endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic [7:0] msr,
    input logic       irq,
    input logic       res_last
);
    AST_TOHOST_READY: assert property (@(posedge clk) disable iff (!rst_n)
        msr[6] |-> (msr[7] && msr[4])); // R2

    AST_NONDMA_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        msr[5] |-> (!msr[7] && !msr[6] && msr[4])); // R12

    AST_READ_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !msr[6]) |-> (rd_data == 8'h00)); // R6

    AST_FINAL_READ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && msr[6] && res_last) |=> (msr == 8'h80 && !irq)); // R7

    AST_RESULT_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && msr[6] && !rd_en) |=> (msr == 8'hD0)); // R5

endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .msr(msr), .irq(irq), .res_last(res_last)
);

// File: tb/fdc_cmd_seq_tb.sv
module fdc_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int EXEC_LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data, msr;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;

    fdc_cmd_seq #(.EXEC_LAT(EXEC_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .msr(msr), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_phase = 0;   // 0 wait opcode, 1 args, 2 exec, 3 result
    int         m_irq = 0, m_nd = 0, m_rw = 0, m_raise = 0;
    int         m_remain = 0, m_cnt = 0, m_kind = 8;
    bit [7:0]   m_cyl = 0, m_op = 0;
    bit [1:0]   m_drv = 0;
    bit [7:0]   m_args[$];
    bit [7:0]   m_res[$];
    bit [7:0]   m_pend[$];

    function automatic void mdecode(input bit [7:0] b, output int kind, output int argc);
        if ((b & 8'h1F) == 8'h06)      begin kind = 0; argc = 8; end
        else if ((b & 8'h3F) == 8'h05) begin kind = 1; argc = 8; end
        else if (b == 8'h0F)           begin kind = 2; argc = 2; end
        else if (b == 8'h08)           begin kind = 3; argc = 0; end
        else if (b == 8'h03)           begin kind = 4; argc = 2; end
        else if (b == 8'h13)           begin kind = 5; argc = 3; end
        else if ((b & 8'h7F) == 8'h14) begin kind = 6; argc = 0; end
        else if (b == 8'h10)           begin kind = 7; argc = 0; end
        else                           begin kind = 8; argc = 0; end
    endfunction

    task automatic mlaunch();
        m_pend.delete();
        m_raise = 0;
        m_rw = (m_kind <= 1);
        m_cnt = 2;
        case (m_kind)
            0, 1: begin
                m_pend.push_back({5'b0, m_args[0][2:0]});
                m_pend.push_back({7'b0, m_op[7]});
                m_pend.push_back(8'h00);
                m_pend.push_back(m_args[1]);
                m_pend.push_back(m_args[2]);
                m_pend.push_back(m_args[3]);
                m_pend.push_back(m_args[4]);
                m_raise = 1;
                m_cnt = EXEC_LAT + 1;
            end
            2: begin m_cyl = m_args[1]; m_drv = m_args[0][1:0]; m_raise = 1; end
            3: if (m_irq != 0) begin
                   m_pend.push_back({6'b001000, m_drv});
                   m_pend.push_back(m_cyl);
               end else m_pend.push_back(8'h80);
            4: m_nd = m_args[1][0];
            5: ;
            6: m_pend.push_back(m_op[7] ? 8'h10 : 8'h00);
            7: m_pend.push_back(8'h90);
            default: m_pend.push_back(8'h80);
        endcase
        m_phase = 2;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_irq = 0; m_nd = 0; m_cyl = 0; m_drv = 0;
            m_res.delete();
        end else begin
            case (m_phase)
                0: if (wr_en) begin
                    int argc;
                    mdecode(wr_data, m_kind, argc);
                    m_op = wr_data;
                    m_args.delete();
                    m_remain = argc;
                    if (argc == 0) mlaunch(); else m_phase = 1;
                end
                1: if (wr_en) begin
                    m_args.push_back(wr_data);
                    m_remain--;
                    if (m_remain == 0) mlaunch();
                end
                2: begin
                    m_cnt--;
                    if (m_cnt == 0) begin
                        if (m_raise != 0) m_irq = 1;
                        m_res = m_pend;
                        m_phase = (m_pend.size() == 0) ? 0 : 3;
                    end
                end
                default: if (rd_en) begin
                    void'(m_res.pop_front());
                    if (m_res.size() == 0) begin m_phase = 0; m_irq = 0; end
                end
            endcase
        end
    end

    function automatic int exp_msr();
        case (m_phase)
            0: return 8'h80;
            1: return 8'h90;
            2: return 8'h10 | ((m_rw != 0 && m_nd != 0) ? 8'h20 : 8'h00);
            default: return 8'hD0;
        endcase
    endfunction

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 status byte", msr, exp_msr());
            check("R10 interrupt", irq, m_irq);
            check("R6 read data", rd_data,
                  (m_phase == 3 && rd_en) ? m_res[0] : 8'h00);
        end
    end

    // ---------------- drivers ----------------
    bit [7:0] txq[$];

    task automatic put(input bit [7:0] b);
        @(negedge clk); #1; wr_en = 1'b1; wr_data = b;
        @(negedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic send();
        foreach (txq[i]) put(txq[i]);
    endtask

    task automatic get(input bit [7:0] exp, input string tag);
        @(negedge clk); #1; rd_en = 1'b1; #1;
        check(tag, rd_data, exp);
        @(negedge clk); #1; rd_en = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 40; i++) begin
            if (m_phase == 0 || m_phase == 3) break;
            @(negedge clk);
        end
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 reset status", msr, 8'h80);
        check("R1 reset irq", irq, 0);
        rd_en = 1'b1; #1;
        check("R1 reset read", rd_data, 8'h00);
        @(negedge clk); #1; rd_en = 1'b0;

        // R9 version, R4 immediate execution
        put(8'h10);
        check("R4 zero-arg enters exec", msr, 8'h10);
        settle();
        get(8'h90, "R9 version byte");
        check("R7 back to command", msr, 8'h80);

        // R8 catch-all, R3 masked mismatch
        put(8'h25); settle();
        check("R8 no irq on unknown", irq, 0);
        get(8'h80, "R3 0x25 falls to catch-all");
        put(8'hFF); settle(); get(8'h80, "R8 unknown 0xFF");

        // R9 lock variants
        put(8'h94); settle(); get(8'h10, "R9 lock");
        put(8'h14); settle(); get(8'h00, "R9 unlock");

        // R11 sense with nothing pending
        put(8'h08); settle(); get(8'h80, "R11 sense idle");

        // R11 seek then sense
        txq = '{8'h0F, 8'h01, 8'h23}; send(); settle();
        check("R13 seek no result", msr, 8'h80);
        check("R11 seek irq", irq, 1);
        put(8'h08);
        check("R4 sense enters exec", msr, 8'h10);
        settle();
        get(8'h21, "R11 sense st0");
        get(8'h23, "R11 sense cylinder");
        check("R7 irq dropped", irq, 0);

        // R12 non-DMA read with multi-track
        txq = '{8'h03, 8'hAF, 8'h01}; send(); settle();
        check("R13 specify no result", msr, 8'h80);
        check("R13 specify no irq", irq, 0);
        txq = '{8'hE6, 8'h01, 8'h05, 8'h00, 8'h03, 8'h02, 8'h12, 8'h1B, 8'hFF};
        send();
        check("R12 non-DMA exec", msr, 8'h30);
        put(8'h10);                      // R5 ignored during exec
        get(8'h00, "R6 read in exec");
        settle();
        check("R10 irq at result", irq, 1);
        get(8'h01, "R10 byte0");
        get(8'h01, "R10 multi-track flag");
        put(8'h10);                      // R5 ignored in result
        check("R5 result kept", msr, 8'hD0);
        get(8'h00, "R10 byte2");
        get(8'h05, "R10 cylinder");
        get(8'h00, "R10 head");
        get(8'h03, "R10 sector");
        get(8'h02, "R10 size");
        check("R7 irq cleared", irq, 0);

        // DMA write, no multi-track
        txq = '{8'h03, 8'hAF, 8'h00}; send(); settle();
        txq = '{8'h05, 8'h00, 8'h07, 8'h01, 8'h09, 8'h02, 8'h12, 8'h1B, 8'hFF};
        send();
        check("R12 DMA exec", msr, 8'h10);
        settle();
        get(8'h00, "R10 write byte0");
        get(8'h00, "R10 write mt clear");
        for (int i = 0; i < 5; i++) get(m_res[0], "R10 write tail");

        // R3 masked read opcode: still collecting after seven bytes
        txq = '{8'h46, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
        send();
        check("R3 0x46 takes 8 args", msr, 8'h90);
        put(8'h07); settle();
        for (int i = 0; i < 7; i++) get(m_res[0], "R3 read result");

        // R13 configure
        txq = '{8'h13, 8'h00, 8'h57, 8'h00}; send(); settle();
        check("R13 configure", msr, 8'h80);

        // R1 reset in the middle of argument collection
        txq = '{8'h0F, 8'h00}; send();
        check("R1 mid-args status", msr, 8'h90);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        check("R1 reset mid-args", msr, 8'h80);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        #1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (R1..R13 sequence): actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule